// File: doc/BRIEF.md
# E3 Overhead Bit Source Selector

This block lives in the transmit path of an E3 framer and settles, once per outbound frame, the values of the two service bits carried in the frame overhead: the alarm bit (A) and the national bit (N). Software sets them up through a small byte-wide register port. That port holds a service-bits register and a transmit configuration register. The configuration register also carries four enable flags, which the block hands straight to the rest of the framer.

For every frame the A bit is taken from one of four places: the service-bits register, an external overhead input, an external payload input, or a far-end block error report. The error report comes from the local receiver's BIP-4 check. The N bit has the same first three choices. The receiver's error flag is captured at the end of each received frame. The selected values are captured on the transmit frame-start strobe and then held for the whole frame. Because of this, a register write made during a frame only takes effect from the next frame.

Top module: `e3_ovh_bit_sel`

## Requirements
- R1: After reset both registers read 0, and `a_bit_out`, `n_bit_out` and all four enable outputs are 0.
- R2: A write to address 0x30 stores all 8 bits, which read back unchanged. A write to address 0x35 stores only bit 1 (A) and bit 0 (N). Bits 7..2 of 0x35 always read 0. Read data is combinational on `reg_addr`.
- R3: Any address other than 0x30 and 0x35 reads as 0, and a write to such an address changes neither register.
- R4: `bip_ins_en`, `ais_en`, `los_en` and `fas_src_sel` equal bits 7, 2, 1 and 0 of the configuration register, and follow a write from the next cycle.
- R5: The A source code is configuration bits 6:5. Code 00 sends service bit 1, 01 sends `ovh_a_in` and 10 sends `pay_a_in`. The value is sampled at the `frame_start` edge.
- R6: With A code 11, the A bit is a far-end block error report. It is 1 if the last receive frame ended with `rx_bip_err` high at its `rx_frame_end` strobe, and 0 otherwise. When `rx_frame_end` and `frame_start` fall in the same cycle, the frame that is just ending is the one reported.
- R7: The N source code is configuration bits 4:3. Code 00 sends service bit 0, 01 sends `ovh_n_in`, 10 sends `pay_n_in` and 11 sends service bit 0.
- R8: `a_bit_out` and `n_bit_out` change only in the cycle after a `frame_start` strobe. A register write in the same cycle as `frame_start` is not seen by that frame.
- R9: Writing service bit 1 = 1 with A code 00 makes every following frame carry A = 1 (remote alarm), until either the bit or the code is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data |
| frame_start | input | 1 | Transmit frame-start strobe |
| rx_frame_end | input | 1 | Receive frame-end strobe |
| rx_bip_err | input | 1 | Receive BIP-4 error for the frame ending now |
| ovh_a_in | input | 1 | A bit from the overhead input |
| ovh_n_in | input | 1 | N bit from the overhead input |
| pay_a_in | input | 1 | A bit from the payload input |
| pay_n_in | input | 1 | N bit from the payload input |
| a_bit_out | output | 1 | A bit for the current frame |
| n_bit_out | output | 1 | N bit for the current frame |
| bip_ins_en | output | 1 | BIP-4 insertion and check enable |
| ais_en | output | 1 | AIS enable |
| los_en | output | 1 | LOS enable |
| fas_src_sel | output | 1 | Frame alignment source select |

## Verification
Two pairs of events can land on the same clock edge. The first pair is the transmit `frame_start` and the receive `rx_frame_end`. The second pair is a register write and `frame_start`. Random stimulus raises all three strobes independently. Directed cycles force each pair to coincide. A reference model in the bench then judges the result. In that model, the frame being captured sees the error flag of the receive frame that is ending now, but it sees the configuration from before the write.

// File: rtl/e3_ovh_bit_sel.sv
module e3_ovh_bit_sel #(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h30,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  input  logic              frame_start,
  input  logic              rx_frame_end,
  input  logic              rx_bip_err,
  input  logic              ovh_a_in,
  input  logic              ovh_n_in,
  input  logic              pay_a_in,
  input  logic              pay_n_in,
  output logic              a_bit_out,
  output logic              n_bit_out,
  output logic              bip_ins_en,
  output logic              ais_en,
  output logic              los_en,
  output logic              fas_src_sel
);
  logic [7:0] cfg_q;
  logic [1:0] svc_q;
  logic       febe_q, a_q, n_q, a_nxt, n_nxt;

  wire cfg_hit  = (reg_addr == CFG_ADDR);
  wire svc_hit  = (reg_addr == SVC_ADDR);
  wire febe_now = rx_frame_end ? rx_bip_err : febe_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q <= '0;
      svc_q <= '0;
    end else if (reg_we) begin
      if (cfg_hit) cfg_q <= reg_wdata;
      if (svc_hit) svc_q <= reg_wdata[1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            febe_q <= 1'b0;
    else if (rx_frame_end) febe_q <= rx_bip_err;

  always_comb begin
    case (cfg_q[6:5])
      2'b00:   a_nxt = svc_q[1];
      2'b01:   a_nxt = ovh_a_in;
      2'b10:   a_nxt = pay_a_in;
      default: a_nxt = febe_now;
    endcase
    case (cfg_q[4:3])
      2'b01:   n_nxt = ovh_n_in;
      2'b10:   n_nxt = pay_n_in;
      default: n_nxt = svc_q[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_q <= 1'b0;
      n_q <= 1'b0;
    end else if (frame_start) begin
      a_q <= a_nxt;
      n_q <= n_nxt;
    end

  assign reg_rdata   = cfg_hit ? cfg_q : svc_hit ? {6'b0, svc_q} : 8'h00;
  assign a_bit_out   = a_q;
  assign n_bit_out   = n_q;
  assign bip_ins_en  = cfg_q[7];
  assign ais_en      = cfg_q[2];
  assign los_en      = cfg_q[1];
  assign fas_src_sel = cfg_q[0];
endmodule

// File: rtl/e3_ovh_bit_sel_chk.sv
module e3_ovh_bit_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       frame_start,
  input logic       rx_frame_end,
  input logic       rx_bip_err,
  input logic       a_bit_out,
  input logic       n_bit_out,
  input logic       bip_ins_en,
  input logic [7:0] cfg_q,
  input logic [1:0] svc_q
);
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 8'h35 |-> reg_rdata[7:2] == 6'b0);

  p_other_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 8'h30 && reg_addr != 8'h35) |-> reg_rdata == 8'h00);

  p_bip_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h30) |=> bip_ins_en == $past(reg_wdata[7]));

  p_reg_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_q[6:5] == 2'b00) |=> a_bit_out == $past(svc_q[1]));

  p_febe_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && rx_frame_end && cfg_q[6:5] == 2'b11) |=> a_bit_out == $past(rx_bip_err));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(a_bit_out) && $stable(n_bit_out));
endmodule

bind e3_ovh_bit_sel e3_ovh_bit_sel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_we(reg_we), .reg_rdata(reg_rdata), .frame_start(frame_start),
  .rx_frame_end(rx_frame_end), .rx_bip_err(rx_bip_err),
  .a_bit_out(a_bit_out), .n_bit_out(n_bit_out), .bip_ins_en(bip_ins_en),
  .cfg_q(cfg_q), .svc_q(svc_q)
);

// File: tb/e3_ovh_bit_sel_tb.sv
module e3_ovh_bit_sel_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic reg_we = 0, frame_start = 0, rx_frame_end = 0, rx_bip_err = 0;
  logic ovh_a_in = 0, ovh_n_in = 0, pay_a_in = 0, pay_n_in = 0;
  logic a_bit_out, n_bit_out, bip_ins_en, ais_en, los_en, fas_src_sel;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] cfg_m = 0;
  logic [1:0] svc_m = 0;
  logic febe_m = 0, a_m = 0, n_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e3_ovh_bit_sel dut_i (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    if (a == 8'h30) return cfg_m;
    if (a == 8'h35) return {6'b0, svc_m};
    return 8'h00;
  endfunction

  function automatic logic sel_a(logic [1:0] c, logic s, logic o, logic p, logic f);
    case (c) 2'b00: return s; 2'b01: return o; 2'b10: return p; default: return f; endcase
  endfunction

  function automatic logic sel_n(logic [1:0] c, logic s, logic o, logic p);
    case (c) 2'b01: return o; 2'b10: return p; default: return s; endcase
  endfunction

  bit fs_prev = 0;

  // inputs already driven after a negedge; check, update model, pass posedge
  task automatic step();
    string ta;
    logic f;
    #1;
    check((reg_addr == 8'h30 || reg_addr == 8'h35) ? "R2 rdata" : "R3 rdata", reg_rdata, exp_rd(reg_addr));
    check("R4 enables", {bip_ins_en, ais_en, los_en, fas_src_sel},
          {4'b0, cfg_m[7], cfg_m[2], cfg_m[1], cfg_m[0]});
    ta = !fs_prev ? "R8 a hold" : (cfg_m[6:5] == 2'b11 ? "R6 a febe" : "R5 a src");
    check(ta, a_bit_out, a_m);
    check(!fs_prev ? "R8 n hold" : "R7 n src", n_bit_out, n_m);
    f = rx_frame_end ? rx_bip_err : febe_m;
    fs_prev = frame_start;
    if (frame_start) begin
      a_m = sel_a(cfg_m[6:5], svc_m[1], ovh_a_in, pay_a_in, f);
      n_m = sel_n(cfg_m[4:3], svc_m[0], ovh_n_in, pay_n_in);
    end
    if (rx_frame_end) febe_m = rx_bip_err;
    if (reg_we && reg_addr == 8'h30) cfg_m = reg_wdata;
    if (reg_we && reg_addr == 8'h35) svc_m = reg_wdata[1:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic [7:0] a, logic [7:0] d, logic we, logic fs, logic fe, logic be);
    reg_addr = a; reg_wdata = d; reg_we = we; frame_start = fs;
    rx_frame_end = fe; rx_bip_err = be;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state while in reset
    check("R1 cfg", dut_i.reg_rdata, 8'h00);
    check("R1 a/n", {a_bit_out, n_bit_out}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    drive(8'h30, 0, 0, 0, 0, 0);
    drive(8'h35, 0, 0, 0, 0, 0);
    // R2 full-width and masked writes
    drive(8'h30, 8'hFF, 1, 0, 0, 0);
    drive(8'h30, 8'h00, 0, 0, 0, 0);
    drive(8'h35, 8'hFF, 1, 0, 0, 0);
    drive(8'h35, 8'h00, 0, 0, 0, 0);
    // R3 stray address: write ignored
    drive(8'h31, 8'h00, 1, 0, 0, 0);
    drive(8'h34, 8'h00, 0, 0, 0, 0);
    drive(8'h30, 8'h00, 0, 0, 0, 0);
    // R9 remote alarm: svc A=1, code 00
    drive(8'h30, 8'h00, 1, 0, 0, 0);
    drive(8'h35, 8'h02, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      drive(8'h35, 0, 0, 1, 0, 0);
      drive(8'h35, 0, 0, 0, 0, 0);
      check("R9 alarm A", a_bit_out, 1'b1);
    end
    // R6 febe with coincident rx end and frame start
    drive(8'h30, 8'h60, 1, 0, 0, 0);
    drive(8'h30, 0, 0, 0, 1, 0);
    drive(8'h30, 0, 0, 1, 1, 1);
    drive(8'h30, 0, 0, 0, 0, 0);
    check("R6 coincident febe", a_bit_out, 1'b1);
    drive(8'h30, 0, 0, 1, 1, 0);
    drive(8'h30, 0, 0, 0, 0, 0);
    check("R6 coincident clear", a_bit_out, 1'b0);
    // R8 write coinciding with frame start uses old config (febe=0 held)
    drive(8'h30, 8'h00, 1, 1, 0, 0);
    drive(8'h30, 0, 0, 0, 0, 0);
    check("R8 old cfg used", a_bit_out, 1'b0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      reg_addr  = (k < 3) ? 8'h30 : (k < 6) ? 8'h35 : 8'($urandom);
      reg_wdata = 8'($urandom);
      reg_we    = ($urandom_range(0, 3) == 0);
      frame_start  = ($urandom_range(0, 2) == 0);
      rx_frame_end = ($urandom_range(0, 2) == 0);
      rx_bip_err   = 1'($urandom);
      ovh_a_in = 1'($urandom); ovh_n_in = 1'($urandom);
      pay_a_in = 1'($urandom); pay_n_in = 1'($urandom);
      step();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule